// File: doc/BRIEF.md
# External Interrupt Line Detector

This block watches a set of external interrupt pins, eight by default, and turns each one into a clean, clock-aligned interrupt request. Each pin first passes through a two-flop synchronizer. It is then judged by one of four rules picked per line: active-low level, falling edge, rising edge, or either edge. In the three edge modes a detected transition is held in a status bit until software clears it. In level mode the status bit shows the live, inverted, synchronized pin and holds nothing.

Software reaches two registers through a plain single-cycle port with a write enable, a register index and a 32-bit data word. Reads are combinational from the index. The detector carries no stream data, so the port has no valid/ready handshake. The clear rule is deliberately narrow. A status bit is cleared only by writing 0 to it while it reads 1 and its line is in an edge mode. Every other write to the status register leaves the bit as it is. This lets a handler write back a value it read earlier without losing an edge that arrived in between.

Top module: `irqdet_top`

## Requirements
- R1: After reset the mode register (index 0) reads zero, every status bit (index 1) reads zero and `irq_out` is all zero. This holds while the pins are held high.
- R2: A pin change is seen in the level-mode status on the second rising clock edge after the change. It is seen in edge-mode status on the third.
- R3: Line n takes its mode from bits [2n+1:2n] of the register at index 0. The encodings are 00 active-low level, 01 falling edge, 10 rising edge and 11 either edge. A write to index 0 loads the whole field, and a read returns it in bits [2N-1:0] with zeros above.
- R4: In an edge mode, a synchronized transition of the selected direction sets the line's status bit (index 1, bit n). The bit stays set until it is cleared.
- R5: In an edge mode, writing index 1 with bit n equal to 0 while status bit n is 1 clears that bit.
- R6: Writing 1 to a status bit changes nothing. Writing 0 to a status bit that reads 0 changes nothing.
- R7: In level mode, status bit n equals the inverse of the synchronized pin and is never latched. Writes to that bit are ignored.
- R8: When a valid clear and a new edge on the same line fall on the same clock edge, the bit ends up set.
- R9: A write that changes a line's mode field clears that line's latched status, and the change itself never produces an edge.
- R10: `irq_out[n]` always equals status bit n.
- R11: Indices other than 0 and 1 read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 8 | Asynchronous external interrupt pins |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| addr | input | 2 | Register index: 0 mode, 1 status |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data for `addr` |
| irq_out | output | 8 | Per-line interrupt request |

## Verification
Two functions can meet on the same clock edge: a new edge landing in a status bit, and a software clear of that same bit. A mode change can also meet an incoming edge. The bench provokes both collisions on purpose. It raises a pin, waits the two synchronizer edges, and issues the clear or the mode write in exactly the cycle where the edge is detected. Random traffic repeats these collisions many more times. The set-wins outcome and the change-clears outcome are each judged against a cycle-accurate bench model. That model is built from the requirements.

// File: rtl/irqdet_pkg.sv
`timescale 1ns/1ps
package irqdet_pkg;

  typedef enum logic [1:0] {
    DET_LOW  = 2'b00,
    DET_FALL = 2'b01,
    DET_RISE = 2'b10,
    DET_BOTH = 2'b11
  } det_mode_e;

  localparam int unsigned REG_MODE = 0;
  localparam int unsigned REG_STAT = 1;

endpackage

// File: rtl/irqdet_sync.sv
`timescale 1ns/1ps
module irqdet_sync #(
  parameter int unsigned WIDTH   = 8,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  localparam logic [WIDTH-1:0] RST_VEC = {WIDTH{RST_VAL}};

  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= RST_VEC;
      stage2_q <= RST_VEC;
    end else begin
      stage1_q <= async_in;
      stage2_q <= stage1_q;
    end
  end

  assign sync_out = stage2_q;

  // R2: second stage always carries what the first held one edge earlier
  a_r2_two_stage: assert property (@(posedge clk) disable iff (!rst_n)
    sync_out == $past(stage1_q));

endmodule

// File: rtl/irqdet_regs.sv
`timescale 1ns/1ps
module irqdet_regs
  import irqdet_pkg::*;
#(
  parameter int unsigned NUM_LINES = 8,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [DATA_W-1:0]      wr_data,
  input  logic [NUM_LINES-1:0]   status,
  output logic [2*NUM_LINES-1:0] mode_q,
  output logic [NUM_LINES-1:0]   mode_chg,
  output logic [NUM_LINES-1:0]   clr_req,
  output logic [DATA_W-1:0]      rd_data
);

  localparam int unsigned MODE_W = 2 * NUM_LINES;

  initial begin
    if (MODE_W > DATA_W) $error("mode field wider than data bus");
  end

  logic sel_mode;
  logic sel_stat;
  logic wr_mode;
  logic wr_stat;
  logic unused_hi;

  assign sel_mode  = (addr == ADDR_W'(REG_MODE));
  assign sel_stat  = (addr == ADDR_W'(REG_STAT));
  assign wr_mode   = wr_en && sel_mode;
  assign wr_stat   = wr_en && sel_stat;
  assign unused_hi = ^wr_data[DATA_W-1:MODE_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
    end else if (wr_mode) begin
      mode_q <= wr_data[MODE_W-1:0];
    end
  end

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_line_ctl
    assign mode_chg[n] = wr_mode && (wr_data[2*n +: 2] != mode_q[2*n +: 2]);
    assign clr_req[n]  = wr_stat && !wr_data[n];
  end

  always_comb begin
    rd_data = '0;
    if (sel_mode) begin
      rd_data[MODE_W-1:0] = mode_q;
    end else if (sel_stat) begin
      rd_data[NUM_LINES-1:0] = status;
    end
  end

  // R3: mode register loads the written field
  a_r3_mode_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mode |=> mode_q == $past(wr_data[MODE_W-1:0]));

  // R11: without a write to index 0 the mode register holds
  a_r11_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_mode |=> $stable(mode_q));

endmodule

// File: rtl/irqdet_line.sv
`timescale 1ns/1ps
module irqdet_line
  import irqdet_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sync_in,
  input  logic [1:0] mode_sel,
  input  logic       mode_chg,
  input  logic       clr_req,
  output logic       status
);

  det_mode_e mode;
  logic      prev_q;
  logic      held_q;
  logic      edge_hit;
  logic      edge_mode;

  assign mode      = det_mode_e'(mode_sel);
  assign edge_mode = (mode != DET_LOW);

  always_comb begin
    case (mode)
      DET_FALL: edge_hit = prev_q && !sync_in;
      DET_RISE: edge_hit = !prev_q && sync_in;
      DET_BOTH: edge_hit = prev_q ^ sync_in;
      default:  edge_hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
    end else begin
      prev_q <= sync_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= 1'b0;
    end else if (mode_chg || !edge_mode) begin
      held_q <= 1'b0;
    end else if (edge_hit) begin
      held_q <= 1'b1;
    end else if (clr_req && held_q) begin
      held_q <= 1'b0;
    end
  end

  assign status = edge_mode ? held_q : !sync_in;

  // R4: a detected edge is captured on the next edge
  a_r4_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && edge_hit && !mode_chg) |=> held_q);

  // R5: a valid clear with no competing edge empties the bit
  a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && held_q && clr_req && !edge_hit && !mode_chg) |=> !held_q);

  // R6: without a clear or mode change a set bit stays set
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && held_q && !clr_req && !mode_chg) |=> held_q);

  // R7: level mode never leaves anything latched
  a_r7_no_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (!edge_mode) |=> !held_q);

  // R8: set wins over a clear on the same edge
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && held_q && clr_req && edge_hit && !mode_chg) |=> held_q);

  // R9: a mode change drops the latched bit
  a_r9_mode_change: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> !held_q);

endmodule

// File: rtl/irqdet_top.sv
`timescale 1ns/1ps
module irqdet_top
  import irqdet_pkg::*;
#(
  parameter int unsigned NUM_LINES = 8,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_in,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wr_data,
  output logic [DATA_W-1:0]    rd_data,
  output logic [NUM_LINES-1:0] irq_out
);

  localparam int unsigned MODE_W = 2 * NUM_LINES;

  logic [NUM_LINES-1:0] sync_pins;
  logic [NUM_LINES-1:0] status;
  logic [MODE_W-1:0]    mode_q;
  logic [NUM_LINES-1:0] mode_chg;
  logic [NUM_LINES-1:0] clr_req;

  irqdet_sync #(
    .WIDTH   (NUM_LINES),
    .RST_VAL (1'b1)
  ) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (irq_in),
    .sync_out (sync_pins)
  );

  irqdet_regs #(
    .NUM_LINES (NUM_LINES),
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .addr     (addr),
    .wr_data  (wr_data),
    .status   (status),
    .mode_q   (mode_q),
    .mode_chg (mode_chg),
    .clr_req  (clr_req),
    .rd_data  (rd_data)
  );

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
    irqdet_line u_line (
      .clk      (clk),
      .rst_n    (rst_n),
      .sync_in  (sync_pins[n]),
      .mode_sel (mode_q[2*n +: 2]),
      .mode_chg (mode_chg[n]),
      .clr_req  (clr_req[n]),
      .status   (status[n])
    );
  end

  assign irq_out = status;

  // R1: no request is raised in the first cycle out of reset
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> irq_out == '0);

endmodule

// File: tb/irqdet_top_tb_top.sv
`timescale 1ns/1ps
module irqdet_top_tb_top;

  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [N-1:0] irq_in = '1;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [N-1:0] irq_out;

  int n_cmp = 0;
  int n_bad = 0;

  logic [N-1:0]   m_s1 = '1, m_s2 = '1, m_prev = '1, m_lat = '0;
  logic [2*N-1:0] m_mode = '0;

  always #5 clk = ~clk;

  irqdet_top dut_i (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .irq_out(irq_out)
  );

  function automatic logic [N-1:0] exp_status();
    logic [N-1:0] s;
    for (int n = 0; n < N; n++)
      s[n] = (m_mode[2*n +: 2] == 2'b00) ? !m_s2[n] : m_lat[n];
    return s;
  endfunction

  function automatic logic [31:0] exp_rd(input logic [1:0] a);
    if (a == 2'd0) return {16'b0, m_mode};
    if (a == 2'd1) return {24'b0, exp_status()};
    return 32'b0;
  endfunction

  task automatic model_step(input logic [N-1:0] pins, input logic we,
                            input logic [1:0] a, input logic [31:0] wd);
    for (int n = 0; n < N; n++) begin
      logic [1:0] md;
      logic hit, chg, clr;
      md  = m_mode[2*n +: 2];
      chg = we && a == 2'd0 && wd[2*n +: 2] != md;
      clr = we && a == 2'd1 && !wd[n];
      case (md)
        2'b01:   hit = m_prev[n] && !m_s2[n];
        2'b10:   hit = !m_prev[n] && m_s2[n];
        2'b11:   hit = m_prev[n] != m_s2[n];
        default: hit = 1'b0;
      endcase
      if (chg || md == 2'b00) m_lat[n] = 1'b0;
      else if (hit)           m_lat[n] = 1'b1;
      else if (clr)           m_lat[n] = 1'b0;
    end
    m_prev = m_s2;
    m_s2   = m_s1;
    m_s1   = pins;
    if (we && a == 2'd0) m_mode = wd[15:0];
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cycle(input logic [N-1:0] pins, input logic we, input logic [1:0] a,
                       input logic [31:0] wd, input string tag);
    irq_in = pins; wr_en = we; addr = a; wr_data = wd;
    @(posedge clk);
    model_step(pins, we, a, wd);
    @(negedge clk);
    wr_en = 1'b0;
    check({tag, " R10 irq_out"}, {24'b0, irq_out}, {24'b0, exp_status()});
    check({tag, " read"}, rd_data, exp_rd(a));
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [N-1:0] pins;
    int unsigned seed;
    seed = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    check("R1 irq_out in reset", {24'b0, irq_out}, 32'b0);
    rst_n = 1'b1;
    addr = 2'd0; #1;
    check("R1 mode after reset", rd_data, 32'b0);
    addr = 2'd1; #1;
    check("R1 status after reset", rd_data, 32'b0);

    // R3 one line per mode, pattern repeated on lines 4..7
    cycle(8'hff, 1'b1, 2'd0, 32'h0000_e4e4, "R3 mode write");
    check("R3 readback", rd_data, 32'h0000_e4e4);
    pins = 8'hff;
    repeat (3) cycle(pins, 1'b0, 2'd1, 0, "idle");

    // R2 level line 0 sees low after two edges
    pins = 8'hfe;
    cycle(pins, 1'b0, 2'd1, 0, "R2 first edge");
    check("R2 not yet", {31'b0, irq_out[0]}, 32'd0);
    cycle(pins, 1'b0, 2'd1, 0, "R2 second edge");
    check("R2 level seen", {31'b0, irq_out[0]}, 32'd1);

    // R4 falling then rising edges on all pins
    pins = 8'h00;
    repeat (3) cycle(pins, 1'b0, 2'd1, 0, "R4 fall");
    check("R4 fall/both latched", {24'b0, irq_out}, 32'h0000_00bb);
    pins = 8'hff;
    repeat (3) cycle(pins, 1'b0, 2'd1, 0, "R4 rise");
    check("R4 all edge lines latched", {24'b0, irq_out}, 32'h0000_00ee);

    // R6 writing ones changes nothing
    cycle(pins, 1'b1, 2'd1, 32'hffff_ffff, "R6 write ones");
    check("R6 ones ignored", {24'b0, irq_out}, 32'h0000_00ee);

    // R5 clear all edge bits
    cycle(pins, 1'b1, 2'd1, 32'h0, "R5 clear");
    check("R5 cleared", {24'b0, irq_out}, 32'h0);
    cycle(pins, 1'b1, 2'd1, 32'h0, "R6 clear of idle bits");
    check("R6 idle clear no effect", {24'b0, irq_out}, 32'h0);

    // R7 level line held low ignores clears
    pins = 8'hfe;
    repeat (2) cycle(pins, 1'b0, 2'd1, 0, "R7 low");
    cycle(pins, 1'b1, 2'd1, 32'h0, "R7 write zero");
    check("R7 level ignores write", {31'b0, irq_out[0]}, 32'd1);

    // R8 line 2 (rising) sets again and is cleared in the same cycle
    pins = 8'hfa;
    repeat (3) cycle(pins, 1'b0, 2'd1, 0, "R8 prep");
    cycle(pins, 1'b1, 2'd1, 32'h0, "R8 pre-clear");
    pins = 8'hfe;
    cycle(pins, 1'b0, 2'd1, 0, "R8 rise a");
    cycle(pins, 1'b0, 2'd1, 0, "R8 rise b");
    cycle(pins, 1'b1, 2'd1, 32'h0, "R8 collide");
    check("R8 set wins", {31'b0, irq_out[2]}, 32'd1);

    // R9 mode change on line 3 (both) collides with an edge
    pins = 8'hf6;
    cycle(pins, 1'b0, 2'd1, 0, "R9 edge a");
    cycle(pins, 1'b0, 2'd1, 0, "R9 edge b");
    cycle(pins, 1'b1, 2'd0, 32'h0000_e4a4, "R9 change");
    check("R9 change clears", {31'b0, irq_out[3]}, 32'd0);
    repeat (3) cycle(pins, 1'b0, 2'd1, 0, "R9 no spurious");
    check("R9 no spurious edge", {31'b0, irq_out[3]}, 32'd0);

    // R11 unmapped indices
    cycle(pins, 1'b1, 2'd2, 32'hffff_ffff, "R11 write idx2");
    cycle(pins, 1'b1, 2'd3, 32'h0, "R11 write idx3");
    addr = 2'd0; #1;
    check("R11 mode untouched", rd_data, 32'h0000_e4a4);

    // random traffic: R4 R5 R6 R7 R8 R9 collisions
    for (int i = 0; i < 4000; i++) begin
      logic [1:0] a;
      logic we;
      logic [31:0] wd;
      if ($urandom % 4 == 0) pins = pins ^ N'($urandom);
      we = ($urandom % 3 == 0);
      a  = ($urandom % 8 == 0) ? 2'($urandom) : (($urandom % 6 == 0) ? 2'd0 : 2'd1);
      wd = $urandom;
      if (a == 2'd1 && $urandom % 2 == 0) wd = 32'hffff_ffff ^ (32'd1 << ($urandom % N));
      cycle(pins, we, a, wd, "R4 R5 R6 R7 R8 R9 random");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule